// File: doc/BRIEF.md
# Stack-Aware Data Memory Unit

This block is the data-memory stage of a small pipelined processor. It holds a word-addressed array of 16-bit words together with the stack pointer that walks down from the top of that array. In ordinary mode it serves loads and stores at an explicit address. In stack mode it moves either one 16-bit word or a 32-bit value spread over two adjacent words. The two-word form saves and restores a 32-bit program counter across calls and interrupts.

Every stack step is checked before the pointer moves. An illegal step is suppressed completely: the pointer stays put, no word is written, and the read register keeps its value. Instead, a one-cycle stack-fault flag is raised. The array depth is set by an address-width parameter. The default is kept small so the array can be simulated. The full-size part uses a width of 20, which gives 1M words.

Loads and pops update a registered 32-bit read port. Single words appear zero-extended in the low half.

Top module: `stack_data_mem`

## Requirements
- R1: After reset the stack pointer equals DEPTH-1 (the highest word address), `rd_data` is 0 and `stk_fault` is 0; a first pop therefore faults.
- R2: With `push` and `pop` both low, `st_en` writes `wr_word` to word `addr`, and `ld_en` loads `{16'h0000, mem[addr]}` into `rd_data`; when both are set on the same address the load returns the word held before the store.
- R3: Single push (`push`=1, `pop`=0, `wide`=0): `wr_word` is stored at mem[SP], then SP decreases by 1.
- R4: Double push (`wide`=1): `pc_in[31:16]` is stored at mem[SP] and `pc_in[15:0]` at mem[SP-1], then SP decreases by 2.
- R5: Single pop (`pop`=1, `push`=0, `wide`=0): SP increases by 1 first, then `rd_data` becomes `{16'h0000, mem[SP]}` using the new SP.
- R6: Double pop (`wide`=1): SP increases by 2 first, then `rd_data` becomes `{mem[SP], mem[SP-1]}` using the new SP, which returns a value saved by R4 unchanged.
- R7: A pop of n words with SP+n > DEPTH-1 is illegal. It raises `stk_fault` for exactly one cycle and leaves SP and `rd_data` unchanged.
- R8: A push of n words with SP < n is illegal. It raises `stk_fault` for one cycle, leaves SP unchanged and writes no memory word.
- R9: `push` and `pop` asserted together do nothing: SP, memory and `rd_data` are unchanged and no fault is raised.
- R10: During a stack operation `ld_en`, `st_en` and `addr` are ignored. No word at `addr` is written by them.
- R11: `rd_data` changes only on a legal load or pop and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address for ordinary load/store |
| wr_word | input | 16 | Store data and single-push data |
| pc_in | input | 32 | Value saved by a double push |
| push | input | 1 | Stack push request |
| pop | input | 1 | Stack pop request |
| wide | input | 1 | 1 = two-word stack transfer, 0 = one word |
| ld_en | input | 1 | Ordinary load enable |
| st_en | input | 1 | Ordinary store enable |
| rd_data | output | 32 | Registered read result |
| stk_fault | output | 1 | One-cycle flag for an illegal stack step |

## Verification
Every result of this block is due at the first rising edge after the cycle in which its request is presented. A load or pop is visible in `rd_data` after that edge, and an illegal step is visible in `stk_fault` after the same edge. A store or push shows its effect only through a later load or pop.

The bench drives each request on a falling edge and queues the expected `{stk_fault, rd_data}` just after the following rising edge. It compares this value at the next falling edge, so each request is checked exactly one edge after it was issued. Held values, such as `rd_data` after a store or after a fault, are checked in the same slot.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_LDST  = 3'd1,
    OP_PUSH1 = 3'd2,
    OP_PUSH2 = 3'd3,
    OP_POP1  = 3'd4,
    OP_POP2  = 3'd5
  } sdm_op_e;

  // push/pop together is a no-op; neither means ordinary load/store
  function automatic sdm_op_e decode_op(input logic push, input logic pop, input logic wide);
    sdm_op_e op;
    if (push && pop)      op = OP_NONE;
    else if (push)        op = wide ? OP_PUSH2 : OP_PUSH1;
    else if (pop)         op = wide ? OP_POP2  : OP_POP1;
    else                  op = OP_LDST;
    return op;
  endfunction

  function automatic logic [1:0] op_words(input sdm_op_e op);
    logic [1:0] n;
    case (op)
      OP_PUSH1, OP_POP1: n = 2'd1;
      OP_PUSH2, OP_POP2: n = 2'd2;
      default:           n = 2'd0;
    endcase
    return n;
  endfunction

  // a push must leave the pointer at or above word 0
  function automatic logic push_fits(input int unsigned sp, input int unsigned n);
    return sp >= n;
  endfunction

  // a pop must not move the pointer past the top word
  function automatic logic pop_fits(input int unsigned sp, input int unsigned n,
                                    input int unsigned top);
    return (sp + n) <= top;
  endfunction

endpackage

// File: rtl/sdm_decode.sv
module sdm_decode
  import sdm_pkg::*;
(
  input  logic       push,
  input  logic       pop,
  input  logic       wide,
  output sdm_op_e    op,
  output logic [1:0] n_words,
  output logic       is_push,
  output logic       is_pop
);

  always_comb begin
    op      = decode_op(push, pop, wide);
    n_words = op_words(op);
    is_push = (op == OP_PUSH1) || (op == OP_PUSH2);
    is_pop  = (op == OP_POP1)  || (op == OP_POP2);
  end

endmodule

// File: rtl/sdm_sp_unit.sv
module sdm_sp_unit
  import sdm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_push,
  input  logic              is_pop,
  input  logic [1:0]        n_words,
  output logic [ADDR_W-1:0] sp_q,
  output logic [ADDR_W-1:0] sp_popped,
  output logic              step_ok,
  output logic              fault_evt,
  output logic              stk_fault_q
);

  localparam int unsigned TOP = (1 << ADDR_W) - 1;
  localparam logic [ADDR_W-1:0] SP_RESET = ADDR_W'(TOP);

  logic [ADDR_W-1:0] step;

  always_comb begin
    step      = ADDR_W'(n_words);
    sp_popped = sp_q + step;
    if (is_push)     step_ok = push_fits(32'(sp_q), 32'(n_words));
    else if (is_pop) step_ok = pop_fits(32'(sp_q), 32'(n_words), TOP);
    else             step_ok = 1'b1;
    fault_evt = (is_push || is_pop) && !step_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q        <= SP_RESET;
      stk_fault_q <= 1'b0;
    end else begin
      stk_fault_q <= fault_evt;
      if (is_push && step_ok)     sp_q <= sp_q - step;
      else if (is_pop && step_ok) sp_q <= sp_popped;
    end
  end

endmodule

// File: rtl/sdm_ram.sv
module sdm_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we_a,
  input  logic [ADDR_W-1:0] wa_a,
  input  logic [DATA_W-1:0] wd_a,
  input  logic              we_b,
  input  logic [ADDR_W-1:0] wa_b,
  input  logic [DATA_W-1:0] wd_b,
  input  logic [ADDR_W-1:0] ra_a,
  input  logic [ADDR_W-1:0] ra_b,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // asynchronous read: the same-cycle store lands after the read
  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];

  always_ff @(posedge clk) begin
    if (we_a) mem[wa_a] <= wd_a;
    if (we_b) mem[wa_b] <= wd_b;
  end

endmodule

// File: rtl/stack_data_mem.sv
module stack_data_mem
  import sdm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wr_word,
  input  logic [31:0]       pc_in,
  input  logic              push,
  input  logic              pop,
  input  logic              wide,
  input  logic              ld_en,
  input  logic              st_en,
  output logic [31:0]       rd_data,
  output logic              stk_fault
);

  sdm_op_e           op;
  logic [1:0]        n_words;
  logic              is_push, is_pop;
  logic [ADDR_W-1:0] sp_q, sp_popped;
  logic              step_ok, fault_evt;

  logic              we_a, we_b;
  logic [ADDR_W-1:0] wa_a, wa_b, ra_a, ra_b;
  logic [15:0]       wd_a, wd_b, rd_a, rd_b;
  logic              rd_load, rd_wide;
  logic [31:0]       rd_q;

  sdm_decode u_dec (
    .push    (push),
    .pop     (pop),
    .wide    (wide),
    .op      (op),
    .n_words (n_words),
    .is_push (is_push),
    .is_pop  (is_pop)
  );

  sdm_sp_unit #(.ADDR_W(ADDR_W)) u_sp (
    .clk         (clk),
    .rst_n       (rst_n),
    .is_push     (is_push),
    .is_pop      (is_pop),
    .n_words     (n_words),
    .sp_q        (sp_q),
    .sp_popped   (sp_popped),
    .step_ok     (step_ok),
    .fault_evt   (fault_evt),
    .stk_fault_q (stk_fault)
  );

  // port A carries the single word or the upper half; port B the lower half
  always_comb begin
    we_a    = 1'b0;
    we_b    = 1'b0;
    wa_a    = addr;
    wa_b    = addr;
    wd_a    = wr_word;
    wd_b    = wr_word;
    ra_a    = addr;
    ra_b    = addr;
    rd_load = 1'b0;
    rd_wide = 1'b0;
    case (op)
      OP_LDST: begin
        we_a    = st_en;
        rd_load = ld_en;
      end
      OP_PUSH1: begin
        we_a = step_ok;
        wa_a = sp_q;
      end
      OP_PUSH2: begin
        we_a = step_ok;
        we_b = step_ok;
        wa_a = sp_q;
        wd_a = pc_in[31:16];
        wa_b = sp_q - ADDR_W'(1);
        wd_b = pc_in[15:0];
      end
      OP_POP1: begin
        ra_a    = sp_popped;
        rd_load = step_ok;
      end
      OP_POP2: begin
        ra_a    = sp_popped;
        ra_b    = sp_popped - ADDR_W'(1);
        rd_load = step_ok;
        rd_wide = 1'b1;
      end
      default: ;
    endcase
  end

  sdm_ram #(.ADDR_W(ADDR_W), .DATA_W(16)) u_ram (
    .clk  (clk),
    .we_a (we_a),
    .wa_a (wa_a),
    .wd_a (wd_a),
    .we_b (we_b),
    .wa_b (wa_b),
    .wd_b (wd_b),
    .ra_a (ra_a),
    .ra_b (ra_b),
    .rd_a (rd_a),
    .rd_b (rd_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_load) rd_q <= rd_wide ? {rd_a, rd_b} : {16'h0000, rd_a};
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/sdm_checker.sv
module sdm_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push,
  input logic              pop,
  input logic              wide,
  input logic [ADDR_W-1:0] sp_q,
  input logic              fault_evt,
  input logic              stk_fault,
  input logic [31:0]       rd_data,
  input logic              rd_load,
  input logic              we_a,
  input logic              we_b,
  input logic [ADDR_W-1:0] wa_a,
  input logic [ADDR_W-1:0] wa_b
);

  p_idle_sp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(push ^ pop) |=> $stable(sp_q));

  p_push1_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !wide && !fault_evt) |=> (sp_q == $past(sp_q) - ADDR_W'(1)));

  p_push2_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && wide && !fault_evt) |=> (sp_q == $past(sp_q) - ADDR_W'(2)));

  p_pop2_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && wide && !fault_evt) |=> (sp_q == $past(sp_q) + ADDR_W'(2)));

  p_fault_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> ($stable(sp_q) && $stable(rd_data) && stk_fault));

  p_fault_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stk_fault |-> $past(fault_evt));

  p_fault_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |-> (!we_a && !we_b));

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_load |=> $stable(rd_data));

  p_ports_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a && we_b) |-> (wa_a != wa_b));

endmodule

bind stack_data_mem sdm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .push      (push),
  .pop       (pop),
  .wide      (wide),
  .sp_q      (sp_q),
  .fault_evt (fault_evt),
  .stk_fault (stk_fault),
  .rd_data   (rd_data),
  .rd_load   (rd_load),
  .we_a      (we_a),
  .we_b      (we_b),
  .wa_a      (wa_a),
  .wa_b      (wa_b)
);

// File: tb/sim_stack_data_mem.sv
`timescale 1ns/1ps
module sim_stack_data_mem;

  localparam int ADDR_W = 10;
  localparam int TOP    = (1 << ADDR_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       wr_word = '0;
  logic [31:0]       pc_in = '0;
  logic              push = 1'b0, pop = 1'b0, wide = 1'b0, ld_en = 1'b0, st_en = 1'b0;
  logic [31:0]       rd_data;
  logic              stk_fault;

  stack_data_mem #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_word(wr_word), .pc_in(pc_in),
    .push(push), .pop(pop), .wide(wide), .ld_en(ld_en), .st_en(st_en),
    .rd_data(rd_data), .stk_fault(stk_fault)
  );

  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // scoreboard: {fault, rd_data} expected one edge after each request
  logic [32:0] exp_q[$];
  string       req_q[$];

  // independent model
  logic [15:0] mdl[int];
  int          sp_m = TOP;
  logic [31:0] exp_rd = '0;

  task automatic drive(input logic ps, input logic pp, input logic wd, input logic r,
                       input logic w, input logic [ADDR_W-1:0] a, input logic [15:0] d,
                       input logic [31:0] pc, input string req);
    logic flt;
    int   n;
    flt = 1'b0;
    n   = wd ? 2 : 1;
    if (ps && !pp) begin
      if (sp_m < n) flt = 1'b1;
      else begin
        if (wd) begin
          mdl[sp_m]     = pc[31:16];
          mdl[sp_m - 1] = pc[15:0];
        end else mdl[sp_m] = d;
        sp_m = sp_m - n;
      end
    end else if (pp && !ps) begin
      if (sp_m + n > TOP) flt = 1'b1;
      else begin
        sp_m   = sp_m + n;
        exp_rd = wd ? {mdl[sp_m], mdl[sp_m - 1]} : {16'h0000, mdl[sp_m]};
      end
    end else if (!ps && !pp) begin
      if (r) exp_rd = {16'h0000, mdl[int'(a)]};
      if (w) mdl[int'(a)] = d;
    end
    @(negedge clk);
    push = ps; pop = pp; wide = wd; ld_en = r; st_en = w;
    addr = a; wr_word = d; pc_in = pc;
    @(posedge clk);
    #1;
    exp_q.push_back({flt, exp_rd});
    req_q.push_back(req);
  endtask

  task automatic t_write(input logic [ADDR_W-1:0] a, input logic [15:0] d, input string req);
    drive(0, 0, 0, 0, 1, a, d, 32'h0, req);
  endtask
  task automatic t_read(input logic [ADDR_W-1:0] a, input string req);
    drive(0, 0, 0, 1, 0, a, 16'h0, 32'h0, req);
  endtask
  task automatic t_push(input logic [15:0] d, input string req);
    drive(1, 0, 0, 0, 0, '0, d, 32'h0, req);
  endtask
  task automatic t_push2(input logic [31:0] pc, input string req);
    drive(1, 0, 1, 0, 0, '0, 16'h0, pc, req);
  endtask
  task automatic t_pop(input string req);
    drive(0, 1, 0, 0, 0, '0, 16'h0, 32'h0, req);
  endtask
  task automatic t_pop2(input string req);
    drive(0, 1, 1, 0, 0, '0, 16'h0, 32'h0, req);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [32:0] e;
        string       r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        tests++;
        if ({stk_fault, rd_data} !== e) begin
          fails++;
          $display("FAIL %s: fault/rd_data got %b/%h expected %b/%h",
                   r, stk_fault, rd_data, e[32], e[31:0]);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    exp_q.push_back(33'h0);           // R1 reset values
    req_q.push_back("R1 reset state");
    t_pop("R1 first pop at top faults");
    t_pop2("R7 double pop at top faults");

    t_write(10'd5, 16'h1111, "R11 store keeps rd_data");
    t_write(10'd6, 16'h2222, "R11 store keeps rd_data");
    t_read(10'd5, "R2 load word 5");
    t_read(10'd6, "R2 load word 6");
    drive(0, 0, 0, 1, 1, 10'd5, 16'h3333, 32'h0, "R2 load-before-store");
    t_read(10'd5, "R2 load after store");

    drive(1, 0, 0, 1, 1, 10'd6, 16'hAAAA, 32'h0, "R10 push ignores ld/st");
    t_read(10'd6, "R10 word at addr untouched");
    t_pop("R5 single pop");
    t_push2(32'hDEADBEEF, "R4 double push");
    t_pop2("R6 double pop returns pc");

    t_push2(32'h12345678, "R4 double push");
    t_pop("R4 low half at lower address");
    t_pop("R4 high half at higher address");
    t_push(16'h0001, "R3 single push");
    t_pop2("R7 double pop with one word faults");
    t_pop("R7 pointer unchanged after fault");

    t_push(16'h7777, "R3 single push");
    drive(1, 1, 0, 1, 1, 10'd5, 16'h9999, 32'h0, "R9 push+pop does nothing");
    t_read(10'd5, "R9 no store during push+pop");
    t_pop("R9 pointer unchanged");

    t_write(10'd0, 16'h0F0F, "R2 store word 0");
    for (int i = 0; i < TOP - 1; i++) t_push(16'(i + 16'h4000), "R3 fill stack");
    t_push2(32'hCAFEF00D, "R8 double push with SP 1 faults");
    t_push(16'hBEEF, "R3 push to SP 1");
    t_push(16'hCAFE, "R8 push with SP 0 faults");
    t_read(10'd0, "R8 word 0 not written by failed push");
    t_pop("R5 pop last pushed");
    t_pop2("R6 double pop of two single words");
    drive(0, 0, 0, 0, 0, '0, 16'h0, 32'h0, "R11 idle hold");

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule